// File: doc/BRIEF.md
# Cyclic Converter Sequencer with Redundancy Correction

This block is the digital side of a cyclic (algorithmic) analog-to-digital converter. One 1.5-bit analog stage is reused for every partial conversion. A pulse on the start input launches a conversion, and the block then runs a fixed number of cycles. In each cycle it captures the two-bit decision of the stage's comparator pair. It returns a registered one-hot DAC level to the stage: subtract the reference, subtract nothing, or add the reference. The stage doubles what is left and feeds it back.

Each decision has half the weight of the one before it. The block adds each new decision into an accumulator that is shifted left by one bit per cycle, so the two-bit decisions overlap by one bit. This overlapped addition is the redundancy correction. It absorbs comparator thresholds that sit off their nominal plus and minus quarter-reference points. When the last decision is in, the corrected word is loaded and a one-cycle completion pulse is raised.

Top module: `cyc_adc_ctrl`

## Requirements
- R1: When `start_i` is high at a clock edge while idle, `busy_o` is high from the next cycle on. Decisions are then captured at the next N_CYC edges. `done_o` is high in the cycle after the last capture.
- R2: `done_o` lasts exactly one cycle. `busy_o` is low while `done_o` is high.
- R3: The decision is coded 2'b10 (input above +VR/4), 2'b01 (middle band) or 2'b00 (below -VR/4). The value captured at an edge appears on `dac_sel_o` in the following cycle. The bit mapping is: 2'b10 gives 3'b100 (subtract reference), 2'b01 gives 3'b010 (zero), 2'b00 gives 3'b001 (add reference). `dac_sel_o` is 3'b000 in any cycle that does not follow a capture.
- R4: A captured code of 2'b11 is handled as 2'b10, both for `dac_sel_o` and for the result. In the same cycle that the DAC level for it is shown, `dec_err_o` is high for one cycle. `dec_err_o` is low otherwise.
- R5: `code_o` (N_CYC+1 bits) equals the sum of d_i·2^(N_CYC-1-i), where d_i is the value 0, 1 or 2 of the i-th decision and the first decision is the most significant.
- R6: A start pulse that arrives while `busy_o` is high has no effect. The conversion in progress keeps its timing and its result.
- R7: `code_o` keeps its value from one completion pulse to the next.
- R8: After reset, `busy_o`, `done_o` and `dec_err_o` are low, `dac_sel_o` is 3'b000 and `code_o` is zero.
- R9: The comparator thresholds may each be displaced by less than VR/4. The input x, scaled to a reference R, then still satisfies |x·2^N_CYC − R·(code − 2^N_CYC + 1)| ≤ R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-conversion request |
| dec_i | input | 2 | 1.5-bit decision from the comparator pair |
| busy_o | output | 1 | Conversion in progress |
| dac_sel_o | output | 3 | One-hot DAC level: [2] subtract, [1] zero, [0] add |
| dec_err_o | output | 1 | Illegal decision code was captured |
| done_o | output | 1 | One-cycle completion pulse |
| code_o | output | N_CYC+1 | Corrected output word |

## Verification
The hardest situation to reach from the ports is redundancy doing its job. That needs comparator thresholds far enough off nominal that an uncorrected converter would lose codes. The bench models the residue loop with integers and sweeps the input across the full range. It repeats the sweep with the upper and lower thresholds displaced independently, up to just under a quarter reference, and checks the result bound on every conversion. Illegal codes and start pulses in the middle of a conversion are injected at chosen cycles within that sweep.

// File: rtl/cyc_adc_pkg.sv
package cyc_adc_pkg;
  typedef enum logic [1:0] {
    DEC_LO  = 2'b00,
    DEC_MID = 2'b01,
    DEC_HI  = 2'b10,
    DEC_BAD = 2'b11
  } dec_e;

  typedef struct packed {
    logic sub;
    logic zero;
    logic add;
  } dac_sel_t;

  // illegal code folds onto the upper decision
  function automatic logic [1:0] legalize(logic [1:0] d);
    return (d == 2'b11) ? 2'b10 : d;
  endfunction
endpackage

// File: rtl/cyc_seq.sv
module cyc_seq #(
  parameter int N_CYC = 10,
  localparam int CNT_W = $clog2(N_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic launch_o,
  output logic capture_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign launch_o  = start_i & ~busy_q;
  assign capture_o = busy_q;
  assign last_o    = busy_q & (cnt_q == CNT_W'(N_CYC - 1));
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_o;
      if (launch_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R6
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o && start_i) |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(N_CYC));
endmodule

// File: rtl/cyc_decode.sv
module cyc_decode
  import cyc_adc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       capture_i,
  input  logic [1:0] dec_i,
  output logic [1:0] dig_o,
  output dac_sel_t   dac_sel_o,
  output logic       err_o
);
  dac_sel_t sel_d, sel_q;
  logic     err_q;

  assign dig_o = legalize(dec_i);

  always_comb begin
    sel_d = '0;
    case (dec_e'(dig_o))
      DEC_HI:  sel_d.sub  = 1'b1;
      DEC_MID: sel_d.zero = 1'b1;
      default: sel_d.add  = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      err_q <= 1'b0;
    end else begin
      sel_q <= capture_i ? sel_d : '0;
      err_q <= capture_i & (dec_i == 2'b11);
    end
  end

  assign dac_sel_o = sel_q;
  assign err_o     = err_q;

  // R3
  dac_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));
  // R4
  err_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> sel_q.sub);
endmodule

// File: rtl/cyc_accum.sv
module cyc_accum #(
  parameter int CODE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              capture_i,
  input  logic              last_i,
  input  logic [1:0]        dig_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] acc_q, acc_nxt, code_q;

  // one-bit overlap: shift by one, add the two-bit decision
  assign acc_nxt = {acc_q[CODE_W-2:0], 1'b0} + CODE_W'(dig_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      code_q <= '0;
    end else begin
      if (launch_i)       acc_q <= '0;
      else if (capture_i) acc_q <= acc_nxt;
      if (last_i)         code_q <= acc_nxt;
    end
  end

  assign code_o = code_q;

  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(code_q));
endmodule

// File: rtl/cyc_adc_ctrl.sv
module cyc_adc_ctrl
  import cyc_adc_pkg::*;
#(
  parameter int N_CYC = 10,
  localparam int CODE_W = N_CYC + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        dec_i,
  output logic              busy_o,
  output logic [2:0]        dac_sel_o,
  output logic              dec_err_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o
);
  logic     launch, capture, last;
  logic [1:0] dig;
  dac_sel_t sel;

  cyc_seq #(.N_CYC(N_CYC)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .launch_o(launch), .capture_o(capture), .last_o(last),
    .busy_o, .done_o
  );

  cyc_decode u_dec (
    .clk_i, .rst_ni, .capture_i(capture), .dec_i,
    .dig_o(dig), .dac_sel_o(sel), .err_o(dec_err_o)
  );

  cyc_accum #(.CODE_W(CODE_W)) u_acc (
    .clk_i, .rst_ni, .launch_i(launch), .capture_i(capture),
    .last_i(last), .dig_i(dig), .code_o
  );

  assign dac_sel_o = sel;

  // R2
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R3
  dac_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_sel_o != 3'b000) |-> $past(busy_o));
  // R1
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/sim_cyc_adc_ctrl.sv
module sim_cyc_adc_ctrl;
  localparam int NC = 6;
  localparam int CW = NC + 1;
  localparam int RR = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    dec = 2'b00;
  logic          busy, err, done;
  logic [2:0]    dac;
  logic [CW-1:0] code;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cyc_adc_ctrl #(.N_CYC(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dec_i(dec),
    .busy_o(busy), .dac_sel_o(dac), .dec_err_o(err), .done_o(done), .code_o(code)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] sel_of(input int d);
    return (d == 2) ? 3'b100 : (d == 1) ? 3'b010 : 3'b001;
  endfunction

  // x: input, ohi/olo: threshold offsets, bad_at: index sending 2'b11, mid_start: start during busy
  task automatic convert(input int x, input int ohi, input int olo, input int bad_at, input bit mid_start);
    int v = x;
    longint expc = 0;
    int pd = 0;
    bit pbad = 0;
    longint lhs;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", busy, 1);
    for (int i = 0; i < NC; i++) begin
      int d;
      if (i > 0) begin
        @(negedge clk);
        chk(dac == sel_of(pd), "R3", dac, sel_of(pd));
        chk(err == pbad, "R4", err, pbad);
        chk(busy && !done, "R1", {busy, done}, 2);
      end
      start = mid_start && (i == 2);
      if (i == bad_at) d = 2;
      else if (v > RR / 4 + ohi) d = 2;
      else if (v < -RR / 4 + olo) d = 0;
      else d = 1;
      dec = (i == bad_at) ? 2'b11 : 2'(d);
      pbad = (i == bad_at);
      pd = d;
      expc += longint'(d) << (NC - 1 - i);
      v = 2 * v - (d - 1) * RR;
    end
    @(negedge clk);
    start = 1'b0;
    chk(dac == sel_of(pd), "R3", dac, sel_of(pd));
    chk(err == pbad, "R4", err, pbad);
    chk(done == 1'b1 && busy == 1'b0, "R2", {busy, done}, 1);
    chk(code == CW'(expc), "R5", code, expc);
    if (bad_at < 0) begin
      lhs = longint'(x) * (1 << NC) - longint'(RR) * (longint'(code) - (1 << NC) + 1);
      chk(lhs <= RR && lhs >= -RR, "R9", lhs, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R2", done, 0);
    chk(dac == 3'b000 && err == 1'b0, "R3", dac, 0);
    chk(code == CW'(expc), "R7", code, expc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35;
    // R8
    chk(busy == 0 && done == 0 && err == 0, "R8", {busy, done, err}, 0);
    chk(dac == 3'b000 && code == '0, "R8", {dac, code}, 0);
    rst_n = 1'b1;
    // R5/R9 sweep with nominal and displaced thresholds
    for (int k = 0; k < 4; k++) begin
      int ohi, olo;
      ohi = (k == 0) ? 0 : (k == 1) ? RR / 8 : (k == 2) ? -(RR / 4 - 1) : RR / 4 - 1;
      olo = (k == 0) ? 0 : (k == 1) ? -(RR / 8) : (k == 2) ? RR / 4 - 1 : -(RR / 4 - 1);
      for (int x = -RR; x <= RR; x += 128) convert(x, ohi, olo, -1, 1'b0);
    end
    // R6: start during conversion
    convert(1000, 0, 0, -1, 1'b1);
    convert(-3000, 300, -200, -1, 1'b1);
    // R4: illegal code at several positions
    convert(-2000, 0, 0, 0, 1'b0);
    convert(500, 0, 0, 3, 1'b0);
    convert(0, 0, 0, NC - 1, 1'b0);
    // R7: idle cycles keep code
    begin
      logic [CW-1:0] held;
      held = code;
      repeat (5) @(negedge clk);
      chk(code == held && !busy, "R7", code, held);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule